// File: doc/BRIEF.md
# RS485 Half-Duplex Transmitter with Driver-Enable Control

This block serializes a byte stream onto a two-wire half-duplex RS485 bus. It drives the transceiver's driver-enable line itself. The enable is raised one bit period ahead of the first start bit, so the line sits at idle while the driver settles. The enable stays up until the stop bit of the last byte has been on the wire for its full width. It is not dropped when the byte is merely handed to the shifter. This prevents the last byte's high-order bits from being corrupted when the line floats back to idle.

Bytes arrive on a valid/ready stream. Bytes that are presented back to back go out with no idle time between frames. The message ends when no byte is waiting at the end of a stop bit. After the last stop bit, a programmable guard of 0 to 15 bit periods can keep the driver on a little longer. The option flag can also place one all-ones preamble byte ahead of the data. On the wire that byte shows only as a single low start bit.

In echo mode the block listens to the local receive line, which the transceiver keeps live while sending. It drops the driver as soon as every transmitted byte has been heard back, never before the final stop bit ends, and at the latest when the guard time expires. A one-clock done pulse marks the release.

Top module: `rs485_de_tx`

## Requirements
- R1: Each byte is sent as a frame of one low start bit, 8 data bits least significant bit first, and one high stop bit, each bit lasting `bit_div` clocks (`bit_div` >= 4).
- R2: When `s_valid` is seen while idle, `de` rises on the next clock edge and `tx_out` stays high for exactly one bit period before the first start bit.
- R3: `s_ready` is high for one cycle at the end of the lead-in and at the end of each stop bit. A byte accepted at the end of a stop bit starts its start bit immediately, with no idle gap.
- R4: Outside echo mode, `de` stays high through the whole final stop bit plus `guard_bits` further bit periods (0 to 15), so it is high for bit_div × (1 + 10 × frames + guard_bits) cycles.
- R5: With `pre_en` set when the message starts, one 0xFF frame is sent before the first data byte without consuming a stream byte.
- R6: With `echo_en` set, `de` drops at the end of the final stop bit if every sent frame has already been received back on `rx_in`. Otherwise it drops when the last echo completes, and at the latest after `guard_bits` bit periods.
- R7: `done` is a one-clock pulse, high exactly in the first cycle in which `de` reads low after a message.
- R8: During and after reset, `de` = 0, `tx_out` = 1, `done` = 0 and `s_ready` = 0, and they stay so while `s_valid` is low.
- R9: Whenever `de` is low, `tx_out` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_div | input | 16 | Clocks per bit period |
| guard_bits | input | 4 | Extra bit periods of enable after the final stop bit |
| pre_en | input | 1 | Send one 0xFF preamble frame first |
| echo_en | input | 1 | Release the driver on echo of the last frame |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_ready | output | 1 | Byte taken on this clock edge when valid |
| rx_in | input | 1 | Local receive line from the transceiver |
| tx_out | output | 1 | Serial transmit line |
| de | output | 1 | Transceiver driver enable |
| done | output | 1 | One-clock pulse at driver release |

## Verification
All timing is measured from the first falling clock edge at which `de` reads high. The first start bit is due after `bit_div` samples. Bit j of frame k is read at bit_div × (1 + 10k + j) + bit_div/2, the middle of that bit's period. The release is due after bit_div × (1 + 10 × frames + guard) high samples, and `done` is checked on the first sample where `de` is low and again one sample later. Every sample is taken on the falling edge, half a clock away from the edge where the registered outputs change. For echo with a delayed loopback, the exact release cycle depends on the synchronizer and receiver sampling. That case is therefore checked against a window: after the last stop bit ends and before the guard time expires.

// File: rtl/rs485_de_pkg.sv
// Shared state encodings for the RS485 driver-enable transmitter.
package rs485_de_pkg;
    // Control sequencing of one message on the bus.
    typedef enum logic [1:0] {
        CTL_IDLE,
        CTL_LEAD,
        CTL_SHIFT,
        CTL_GUARD
    } ctl_state_t;

    // Echo receiver framing states.
    typedef enum logic [1:0] {
        ERX_IDLE,
        ERX_START,
        ERX_DATA,
        ERX_STOP
    } erx_state_t;
endpackage

// File: rtl/rs485_bit_timer.sv
// Bit-period timer. Produces a one-clock tick every `period` clocks while
// `run` is high; while stopped it preloads, so the first tick comes a full
// period after run rises. Assumes period >= 2.
module rs485_bit_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] period,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    // Count down, reload on expiry or while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || cnt_q == '0)
            cnt_q <= period - DIV_W'(1);
        else
            cnt_q <= cnt_q - DIV_W'(1);
    end

    assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/rs485_tx_shifter.sv
// Frame serializer. On `load` it starts a start bit and holds the data plus
// a stop bit; each `advance` moves to the next bit, LSB first. `last_bit`
// flags that the stop bit is on the line. The line rests high.
module rs485_tx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_byte,
    input  logic              advance,
    output logic              tx,
    output logic              last_bit
);
    localparam int FRAME_BITS = DATA_W + 2;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    logic [DATA_W:0]  sh_q;
    logic [CNT_W-1:0] idx_q;
    logic             tx_q;

    // Serializer: load a frame or step to its next bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '1;
            idx_q <= '0;
            tx_q  <= 1'b1;
        end else if (load) begin
            sh_q  <= {1'b1, load_byte};
            idx_q <= '0;
            tx_q  <= 1'b0;
        end else if (advance) begin
            tx_q  <= sh_q[0];
            sh_q  <= {1'b1, sh_q[DATA_W:1]};
            idx_q <= idx_q + CNT_W'(1);
        end
    end

    assign tx       = tx_q;
    assign last_bit = (idx_q == CNT_W'(FRAME_BITS - 1));

    // R1: a loaded frame always begins with a low start bit.
    p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !tx);
endmodule

// File: rtl/rs485_echo_rx.sv
// Echo receiver. Synchronizes the local receive line, finds start bits,
// samples mid-bit and pulses `frame_ok` at the middle of a valid stop bit.
// Only frame completion is reported; the data value is not needed.
module rs485_echo_rx #(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_in,
    input  logic [DIV_W-1:0] bit_div,
    output logic             frame_ok
);
    import rs485_de_pkg::*;
    localparam int BIT_W = $clog2(DATA_W);

    logic             s1_q, s2_q, ok_q;
    erx_state_t       st_q;
    logic [DIV_W-1:0] cnt_q;
    logic [BIT_W-1:0] bit_q;

    // Two-stage synchronizer for the asynchronous receive line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= rx_in;
            s2_q <= s1_q;
        end
    end

    // Framing: start detect, mid-bit sampling, stop validation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ERX_IDLE;
            cnt_q <= '0;
            bit_q <= '0;
            ok_q  <= 1'b0;
        end else begin
            ok_q <= 1'b0;
            if (st_q == ERX_IDLE) begin
                if (!s2_q) begin
                    st_q  <= ERX_START;
                    cnt_q <= (bit_div >> 1) - DIV_W'(1);
                end
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - DIV_W'(1);
            end else begin
                cnt_q <= bit_div - DIV_W'(1);
                case (st_q)
                    ERX_START: begin
                        st_q  <= s2_q ? ERX_IDLE : ERX_DATA;
                        bit_q <= '0;
                    end
                    ERX_DATA: begin
                        if (bit_q == BIT_W'(DATA_W - 1))
                            st_q <= ERX_STOP;
                        bit_q <= bit_q + BIT_W'(1);
                    end
                    default: begin
                        ok_q <= s2_q;
                        st_q <= ERX_IDLE;
                    end
                endcase
            end
        end
    end

    assign frame_ok = ok_q;

    // R6: each heard frame is reported once.
    p_echo_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |=> !frame_ok);
endmodule

// File: rtl/rs485_de_tx.sv
// RS485 half-duplex transmitter with driver-enable sequencing. Raises the
// enable one bit period before the first start bit, streams frames back to
// back while bytes are offered, and releases only after the final stop bit
// has fully elapsed plus a guard time, or on echo of the last frame.
// Assumes bit_div >= 4 and stable configuration during a message.
module rs485_de_tx #(
    parameter int DIV_W   = 16,
    parameter int DATA_W  = 8,
    parameter int GUARD_W = 4,
    parameter int PEND_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIV_W-1:0]   bit_div,
    input  logic [GUARD_W-1:0] guard_bits,
    input  logic               pre_en,
    input  logic               echo_en,
    input  logic               s_valid,
    input  logic [DATA_W-1:0]  s_data,
    output logic               s_ready,
    input  logic               rx_in,
    output logic               tx_out,
    output logic               de,
    output logic               done
);
    import rs485_de_pkg::*;

    ctl_state_t         st_q;
    logic               de_q, done_q, pre_q;
    logic [GUARD_W-1:0] g_q;
    logic [PEND_W-1:0]  pend_q, pend_eff;
    logic               tick, last_bit, heard_frame;
    logic               lead_end, frame_end, load_pre, load_data, load;
    logic               advance, heard, out_of_data, release_now, go_guard;
    logic [DATA_W-1:0]  next_byte;

    rs485_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st_q != CTL_IDLE),
        .period (bit_div),
        .tick   (tick)
    );

    rs485_tx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_byte (next_byte),
        .advance   (advance),
        .tx        (tx_out),
        .last_bit  (last_bit)
    );

    rs485_echo_rx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_echo (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_in    (rx_in),
        .bit_div  (bit_div),
        .frame_ok (heard_frame)
    );

    // Decode the bit-boundary events and the release decision.
    always_comb begin
        lead_end    = (st_q == CTL_LEAD) && tick;
        frame_end   = (st_q == CTL_SHIFT) && tick && last_bit;
        advance     = (st_q == CTL_SHIFT) && tick && !last_bit;
        s_ready     = (lead_end && !pre_q) || frame_end;
        load_pre    = lead_end && pre_q;
        load_data   = s_ready && s_valid;
        load        = load_pre || load_data;
        next_byte   = load_pre ? '1 : s_data;
        pend_eff    = (heard_frame && pend_q != '0) ? pend_q - PEND_W'(1) : pend_q;
        heard       = echo_en && (pend_eff == '0);
        out_of_data = s_ready && !s_valid;
        release_now = (out_of_data && ((st_q == CTL_LEAD) || guard_bits == '0 || heard))
                   || ((st_q == CTL_GUARD) && (heard || (tick && g_q == GUARD_W'(1))));
        go_guard    = out_of_data && !release_now;
    end

    // Message sequencer: lead-in, shifting, guard, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= CTL_IDLE;
            de_q   <= 1'b0;
            done_q <= 1'b0;
            pre_q  <= 1'b0;
            g_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (release_now) begin
                st_q   <= CTL_IDLE;
                de_q   <= 1'b0;
                done_q <= 1'b1;
            end else if (st_q == CTL_IDLE) begin
                if (s_valid) begin
                    st_q  <= CTL_LEAD;
                    de_q  <= 1'b1;
                    pre_q <= pre_en;
                end
            end else if (load) begin
                st_q <= CTL_SHIFT;
                if (load_pre)
                    pre_q <= 1'b0;
            end else if (go_guard) begin
                st_q <= CTL_GUARD;
                g_q  <= guard_bits;
            end else if (st_q == CTL_GUARD && tick) begin
                g_q <= g_q - GUARD_W'(1);
            end
        end
    end

    // Frames sent but not yet heard back; cleared at release.
    always_ff @(posedge clk) begin
        if (!rst_n || release_now)
            pend_q <= '0;
        else
            pend_q <= pend_eff + PEND_W'(load && pend_eff != '1);
    end

    assign de   = de_q;
    assign done = done_q;

    // R9: the line rests high whenever the driver is off.
    p_line_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> tx_out);
    // R7: done marks the first cycle with the driver off.
    p_done_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!de && $past(de)));
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2: the enable comes up over an idle line.
    p_lead_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(de) |-> tx_out);
    // R3: bytes are only taken while driving.
    p_ready_driving_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> de);
    // R4: release never cuts a low bit short.
    p_release_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(de) |-> $past(tx_out));
endmodule

// File: tb/rs485_de_tx_test.sv
module rs485_de_tx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bit_div = 16'd4;
    logic [3:0]  guard_bits = 4'd0;
    logic        pre_en = 1'b0, echo_en = 1'b0, s_valid = 1'b0;
    logic [7:0]  s_data = 8'h00;
    logic        s_ready, rx_in, tx_out, de, done;
    logic [39:0] dly;
    int          loop_mode = 0;
    int          checks = 0, fails = 0, cyc = 0;
    logic        txlog [0:1023];

    always #4 clk = ~clk;

    rs485_de_tx uut (
        .clk(clk), .rst_n(rst_n), .bit_div(bit_div), .guard_bits(guard_bits),
        .pre_en(pre_en), .echo_en(echo_en), .s_valid(s_valid), .s_data(s_data),
        .s_ready(s_ready), .rx_in(rx_in), .tx_out(tx_out), .de(de), .done(done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) dly <= '1;
        else        dly <= {dly[38:0], tx_out};
    end
    assign rx_in = (loop_mode == 0) ? 1'b1 : ((loop_mode == 1) ? tx_out : dly[19]);

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input int v, input int k);
        return 8'(v * 37 + k * 89 + 3);
    endfunction

    // Columns: bit_div, bytes, preamble, guard, echo, loop mode, expected de cycles
    localparam int NV = 6;
    localparam int VEC [NV][7] = '{
        '{ 4, 1, 0,  0, 0, 0,  44},
        '{ 4, 2, 0,  3, 0, 0,  96},
        '{ 6, 1, 1,  2, 0, 0, 138},
        '{ 5, 3, 0, 15, 0, 0, 230},
        '{10, 2, 0,  7, 1, 1, 210},
        '{10, 1, 1,  4, 1, 1, 210}
    };

    task automatic run_msg(input int v, input int n, input int nb, input int pre,
                           input int g, input int echo, input int mode,
                           output int de_cnt);
        int  sent = 0, t = 0, lead = -1, guard_loop = 0;
        logic seen = 1'b0, fin = 1'b0, acc;
        bit_div = 16'(n); guard_bits = 4'(g); pre_en = pre[0]; echo_en = echo[0];
        loop_mode = mode;
        s_data = byte_of(v, 0);
        s_valid = 1'b1;
        while (!fin && guard_loop < 3000) begin
            guard_loop++;
            @(negedge clk);
            if (de) begin
                if (t < 1024) txlog[t] = tx_out;
                if (lead < 0 && !tx_out) lead = t;
                t++;
                seen = 1'b1;
            end else if (seen) begin
                chk(done == 1'b1, "R7 done at release", int'(done), 1);
                fin = 1'b1;
            end
            acc = s_valid && s_ready;
            @(posedge clk); #1;
            if (acc) begin
                sent++;
                if (sent < nb) s_data = byte_of(v, sent);
                else           s_valid = 1'b0;
            end
        end
        s_valid = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
        chk(lead == n, "R2 lead-in length", lead, n);
        chk(sent == nb, "R3 bytes accepted", sent, nb);
        for (int k = 0; k < nb + pre; k++) begin
            int t0 = n + 10 * n * k;
            logic [7:0] got = 8'h00;
            logic [7:0] exp = (pre != 0 && k == 0) ? 8'hFF : byte_of(v, k - pre);
            for (int j = 0; j < 8; j++) got[j] = txlog[t0 + (j + 1) * n + n / 2];
            chk(txlog[t0 + n / 2] == 1'b0, "R1 start bit", int'(txlog[t0 + n / 2]), 0);
            chk(got == exp, (pre != 0 && k == 0) ? "R5 preamble byte" : "R1 R3 data byte",
                int'(got), int'(exp));
            chk(txlog[t0 + 9 * n + n / 2] == 1'b1, "R1 stop bit",
                int'(txlog[t0 + 9 * n + n / 2]), 1);
        end
        de_cnt = t;
        repeat (30) begin
            @(negedge clk);
        end
        chk(de == 1'b0 && tx_out == 1'b1, "R9 idle after message", int'(de), 0);
    endtask

    initial begin
        int dc;
        repeat (4) @(negedge clk);
        chk(de == 1'b0 && tx_out == 1'b1 && done == 1'b0 && s_ready == 1'b0,
            "R8 outputs in reset", int'({de, tx_out, done, s_ready}), 4);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(de == 1'b0 && tx_out == 1'b1 && s_ready == 1'b0,
            "R8 quiet without valid", int'({de, tx_out, s_ready}), 2);
        @(posedge clk); #1;

        for (int v = 0; v < NV; v++) begin
            run_msg(v, VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], dc);
            chk(dc == VEC[v][6], VEC[v][4] != 0 ? "R6 echo release" : "R4 enable span",
                dc, VEC[v][6]);
        end

        // R6: no echo heard, guard time bounds the release.
        run_msg(10, 6, 1, 0, 4, 1, 0, dc);
        chk(dc == 90, "R6 echo timeout", dc, 90);
        // R6: no echo and zero guard releases at the end of the stop bit.
        run_msg(11, 6, 1, 0, 0, 1, 0, dc);
        chk(dc == 66, "R6 zero guard", dc, 66);
        // R6: late echo releases after the stop bit and before guard expiry.
        run_msg(12, 10, 1, 0, 4, 1, 2, dc);
        chk(dc > 110 && dc < 150, "R6 late echo window", dc, 130);
        // R4: zero guard with echo disabled, two bytes with preamble.
        run_msg(13, 4, 2, 1, 0, 0, 0, dc);
        chk(dc == 124, "R4 zero guard preamble", dc, 124);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule